// File: doc/BRIEF.md
# Nested Priority In-Service Register

This block keeps track of which priority levels of a fast interrupt path are being serviced while nesting is allowed. It holds one status bit per level, and level 0 is the most urgent. When nesting is enabled and the handler fetches its vector, the bit for the level of the winning interrupt is recorded. The block keeps the set bits until the handler acknowledges them.

From the recorded levels the block derives a blocking mask. A level is masked when it is equal to or less urgent than the most urgent level in service. Incoming requests whose priority falls in the masked range are held back, so only strictly more urgent requests reach the core.

The acknowledge works like popping a stack. Any write strobe removes only the most urgent recorded level. Written data plays no part, so repeated writes unwind the nesting one level at a time.

Top module: `nest_isr_tracker`

## Requirements
- R1: After reset the status register reads 0x00, the mask is all zero, and every request passes unchanged.
- R2: With nesting enabled, a vector-read strobe sets the status bit numbered by the vector priority input. The bit shows on the clock edge that samples the strobe.
- R3: With nesting disabled, a vector-read strobe sets no status bit.
- R4: Mask bit p is 1 exactly when some status bit k with k <= p is set. The mask follows the register in the same cycle.
- R5: A request with priority p is passed in the same cycle only when p is strictly less than the lowest-numbered set status bit. When no bit is set, every request passes.
- R6: A write strobe clears only the lowest-numbered set bit, one bit per write. Starting from 0x09, one write gives 0x08 and a second write gives 0x00.
- R7: A write strobe while the register is 0x00 leaves it at 0x00.
- R8: When a write and an enabled vector read fall in the same cycle, the clear is applied first and the new bit is set afterwards. From 0x04, a write together with a read at priority 1 gives 0x02.
- R9: Without any strobe the register holds its value. Writes still clear bits while nesting is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nest_en_i | input | 1 | Nesting enable |
| vec_rd_i | input | 1 | Vector-read strobe |
| vec_prio_i | input | PRIO_W | Priority of the interrupt being serviced |
| wr_i | input | 1 | Acknowledge write strobe |
| req_i | input | NUM_REQ | Pending requests |
| req_prio_i | input | NUM_REQ*PRIO_W | Priority of each request, request i in bits [i*PRIO_W +: PRIO_W] |
| isr_o | output | NUM_LVL | In-service status register |
| mask_o | output | NUM_LVL | Blocked levels |
| req_o | output | NUM_REQ | Requests passed by the mask |

## Verification
Strobe effects on the status register take one register stage, so they are due on the first rising edge after the strobe is driven. The mask and the request filter are combinational from the register and the request inputs, so they are due in the same cycle. The bench drives inputs on the falling edge and checks the register one time unit after the next rising edge. It checks the mask and the filter after a short settle delay, with no clock edge in between. The expected register value comes from a bench model that applies the clear before the set.

// File: rtl/nest_isr_pkg.sv
package nest_isr_pkg;
  localparam int unsigned DEF_LVLS = 8;
  localparam int unsigned DEF_REQS = 4;
endpackage

// File: rtl/isr_pop_unit.sv
module isr_pop_unit #(
  parameter int unsigned NUM_LVL = 8
) (
  input  logic [NUM_LVL-1:0] isr_i,
  output logic [NUM_LVL-1:0] popped_o
);
  // x & (x-1) drops the lowest set bit; zero stays zero
  always_comb popped_o = isr_i & (isr_i - NUM_LVL'(1));
endmodule

// File: rtl/isr_mask_gen.sv
module isr_mask_gen #(
  parameter int unsigned NUM_LVL = 8
) (
  input  logic [NUM_LVL-1:0] isr_i,
  output logic [NUM_LVL-1:0] mask_o
);
  logic [NUM_LVL:0] seen;
  assign seen[0] = 1'b0;
  for (genvar g = 0; g < NUM_LVL; g++) begin : g_chain
    assign seen[g+1] = seen[g] | isr_i[g];
  end
  assign mask_o = seen[NUM_LVL:1];
endmodule

// File: rtl/isr_req_filter.sv
module isr_req_filter #(
  parameter int unsigned NUM_LVL = 8,
  parameter int unsigned NUM_REQ = 4,
  localparam int unsigned PRIO_W = $clog2(NUM_LVL)
) (
  input  logic [NUM_LVL-1:0]        mask_i,
  input  logic [NUM_REQ-1:0]        req_i,
  input  logic [NUM_REQ*PRIO_W-1:0] req_prio_i,
  output logic [NUM_REQ-1:0]        req_o
);
  for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
    logic [PRIO_W-1:0] prio;
    assign prio     = req_prio_i[g*PRIO_W +: PRIO_W];
    assign req_o[g] = req_i[g] & ~mask_i[prio];
  end
endmodule

// File: rtl/nest_isr_tracker.sv
module nest_isr_tracker
  import nest_isr_pkg::*;
#(
  parameter int unsigned NUM_LVL = DEF_LVLS,
  parameter int unsigned NUM_REQ = DEF_REQS,
  localparam int unsigned PRIO_W = $clog2(NUM_LVL)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      nest_en_i,
  input  logic                      vec_rd_i,
  input  logic [PRIO_W-1:0]         vec_prio_i,
  input  logic                      wr_i,
  input  logic [NUM_REQ-1:0]        req_i,
  input  logic [NUM_REQ*PRIO_W-1:0] req_prio_i,
  output logic [NUM_LVL-1:0]        isr_o,
  output logic [NUM_LVL-1:0]        mask_o,
  output logic [NUM_REQ-1:0]        req_o
);
  logic [NUM_LVL-1:0] isr_q, popped, after_clr, isr_d;

  isr_pop_unit #(.NUM_LVL(NUM_LVL)) u_pop (
    .isr_i(isr_q), .popped_o(popped)
  );

  // clear first, then set
  always_comb begin
    after_clr = wr_i ? popped : isr_q;
    isr_d     = after_clr;
    if (nest_en_i && vec_rd_i) isr_d[vec_prio_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= isr_d;
  end

  isr_mask_gen #(.NUM_LVL(NUM_LVL)) u_mask (
    .isr_i(isr_q), .mask_o(mask_o)
  );

  isr_req_filter #(.NUM_LVL(NUM_LVL), .NUM_REQ(NUM_REQ)) u_filt (
    .mask_i(mask_o), .req_i(req_i), .req_prio_i(req_prio_i), .req_o(req_o)
  );

  assign isr_o = isr_q;
endmodule

// File: rtl/nest_isr_chk.sv
module nest_isr_chk #(
  parameter int unsigned NUM_LVL = 8,
  parameter int unsigned NUM_REQ = 4,
  localparam int unsigned PRIO_W = $clog2(NUM_LVL)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 nest_en_i,
  input logic                 vec_rd_i,
  input logic [PRIO_W-1:0]    vec_prio_i,
  input logic                 wr_i,
  input logic [NUM_REQ-1:0]   req_i,
  input logic [NUM_LVL-1:0]   isr_o,
  input logic [NUM_REQ-1:0]   req_o
);
  a_r2_set_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nest_en_i && vec_rd_i) |=> isr_o[$past(vec_prio_i)]);

  a_r3_no_set_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nest_en_i && vec_rd_i) |=> ((isr_o & ~$past(isr_o)) == '0));

  a_r5_idle_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isr_o == '0) |-> (req_o == req_i));

  a_r5_top_blocks_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isr_o[0] |-> (req_o == '0));

  a_r5_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_o & ~req_i) == '0));

  a_r6_pop_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !(nest_en_i && vec_rd_i) && isr_o != '0)
      |=> ($countones(isr_o) == $countones($past(isr_o)) - 1));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !vec_rd_i) |=> $stable(isr_o));
endmodule

bind nest_isr_tracker nest_isr_chk #(.NUM_LVL(NUM_LVL), .NUM_REQ(NUM_REQ)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .nest_en_i(nest_en_i), .vec_rd_i(vec_rd_i),
  .vec_prio_i(vec_prio_i), .wr_i(wr_i), .req_i(req_i), .isr_o(isr_o), .req_o(req_o)
);

// File: tb/nest_isr_tracker_bench.sv
`timescale 1ns/1ps
module nest_isr_tracker_bench;
  localparam int NL = 8;
  localparam int NR = 4;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nest_en = 1'b0, vec_rd = 1'b0, wr = 1'b0;
  logic [PW-1:0] vec_prio = '0;
  logic [NR-1:0] req = '0;
  logic [NR*PW-1:0] req_prio = '0;
  logic [NL-1:0] isr, mask;
  logic [NR-1:0] req_out;

  int n_chk = 0, n_bad = 0;
  logic [NL-1:0] exp_isr = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nest_isr_tracker u_nest_isr_tracker (
    .clk_i(clk), .rst_ni(rst_n), .nest_en_i(nest_en), .vec_rd_i(vec_rd),
    .vec_prio_i(vec_prio), .wr_i(wr), .req_i(req), .req_prio_i(req_prio),
    .isr_o(isr), .mask_o(mask), .req_o(req_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NL-1:0] exp_mask(input logic [NL-1:0] s);
    logic seen = 1'b0;
    for (int i = 0; i < NL; i++) begin
      seen = seen | s[i];
      exp_mask[i] = seen;
    end
  endfunction

  // one clock: drive on falling edge, check after rising edge
  task automatic step(input logic ne, input logic rd, input int p, input logic w, input string tag);
    @(negedge clk);
    nest_en = ne; vec_rd = rd; vec_prio = PW'(p); wr = w;
    if (w) begin
      for (int i = 0; i < NL; i++)
        if (exp_isr[i]) begin exp_isr[i] = 1'b0; break; end
    end
    if (ne && rd) exp_isr[p] = 1'b1;
    @(posedge clk); #1;
    vec_rd = 1'b0; wr = 1'b0;
    check(tag, 32'(isr), 32'(exp_isr));
  endtask

  task automatic drain();
    for (int i = 0; i < NL; i++) step(1'b0, 1'b0, 0, 1'b1, "R9 drain");
  endtask

  task automatic t_reset();
    req = 4'b1011; req_prio = {3'd7, 3'd0, 3'd3, 3'd5}; #1;
    check("R1 isr", 32'(isr), 0);
    check("R1 mask", 32'(mask), 0);
    check("R1 req", 32'(req_out), 32'(4'b1011));
  endtask

  task automatic t_set();
    step(1'b1, 1'b1, 5, 1'b0, "R2 set p5");
    step(1'b1, 1'b1, 2, 1'b0, "R2 set p2");
    check("R4 mask 0x24", 32'(mask), 32'(exp_mask(8'h24)));
  endtask

  task automatic t_no_nest();
    step(1'b0, 1'b1, 6, 1'b0, "R3 read while off");
    step(1'b0, 1'b1, 0, 1'b0, "R3 read p0 while off");
  endtask

  task automatic t_filter();
    // isr is 0x24 here: lowest set bit is 2
    for (int p = 0; p < NL; p++) begin
      req = 4'b0001; req_prio = {9'd0, 3'(p)}; #1;
      check($sformatf("R5 prio %0d", p), 32'(req_out[0]), 32'(p < 2));
    end
    req = 4'b1111; req_prio = {3'd1, 3'd2, 3'd0, 3'd6}; #1;
    check("R5 mixed", 32'(req_out), 32'(4'b1010));
  endtask

  task automatic t_pop();
    step(1'b0, 1'b0, 0, 1'b1, "R6 pop 0x24");
    check("R4 mask 0x20", 32'(mask), 32'(exp_mask(8'h20)));
    step(1'b0, 1'b0, 0, 1'b1, "R9 pop while off");
    step(1'b1, 1'b1, 3, 1'b0, "R2 set p3");
    step(1'b1, 1'b1, 0, 1'b0, "R2 set p0");
    check("R6 is 0x09", 32'(isr), 32'h09);
    step(1'b1, 1'b0, 0, 1'b1, "R6 0x09 to 0x08");
    check("R6 0x08", 32'(isr), 32'h08);
    step(1'b1, 1'b0, 0, 1'b1, "R6 0x08 to 0x00");
    check("R6 0x00", 32'(isr), 32'h00);
  endtask

  task automatic t_empty_wr();
    step(1'b1, 1'b0, 0, 1'b1, "R7 write on empty");
    step(1'b0, 1'b0, 0, 1'b1, "R7 write on empty off");
  endtask

  task automatic t_both();
    step(1'b1, 1'b1, 2, 1'b0, "R2 set p2");
    step(1'b1, 1'b1, 1, 1'b1, "R8 0x04 to 0x02");
    check("R8 value", 32'(isr), 32'h02);
    step(1'b1, 1'b1, 1, 1'b1, "R8 same level re-set");
    step(1'b1, 1'b1, 7, 1'b0, "R2 set p7");
    step(1'b1, 1'b1, 4, 1'b1, "R8 0x82 to 0x90");
    check("R8 value 2", 32'(isr), 32'h90);
  endtask

  task automatic t_hold();
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 0, 1'b0, "R9 hold");
    check("R4 mask 0x90", 32'(mask), 32'(exp_mask(8'h90)));
    drain();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #9; t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_set();
    t_no_nest();
    t_filter();
    t_pop();
    t_empty_wr();
    t_both();
    t_hold();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule